// File: doc/BRIEF.md
# Execution Port Reservation Scheduler

This block holds a reservation map covering a bounded window of cycles, with three execution ports per cycle. A requester presents a scheduling request for one operation. The request carries up to two micro-op port masks, a start cycle, a dependency cycle, a dependent flag and a commit flag. The block searches forward from the first eligible cycle, one cycle per clock, for the earliest cycle at which the requested ports are free. It then pulses `done` and reports either that cycle or a failure.

A request made in probe mode only answers the question "where would this land". A request made in commit mode also books the chosen port slots, so later requests see them as busy. A synchronous clear empties the whole map, which lets a new scheduling pass start from a clean state.

Port mask encoding, used on both mask inputs:
- bit 0 selects port A.
- bit 1 selects port B.
- bit 2 selects port C.

Masks may combine these bits, for example 3'b011, 3'b101 or 3'b111.

Top module: `port_resv_sched`

## Requirements
- R1: After reset, `done` and `busy` are low and every port slot of the map is free. Asserting `clr` for one clock also frees every slot.
- R2: Within one cycle, the ports allowed by a mask are tried in the fixed order bit 2 (port C), then bit 0 (port A), then bit 1 (port B). The first free port in that order is taken.
- R3: When none of the allowed ports is free at the cycle under test, the search moves on to the next cycle.
- R4: If the search reaches cycle index DEPTH without a fit, the block reports `fail`. This includes a search that starts at or beyond DEPTH. A successful result always lies below DEPTH.
- R5: A request whose first mask is zero is eliminated. It completes on its acceptance edge with `res_cycle` equal to the eligible start cycle and `fail` low. It reserves nothing.
- R6: A request with a nonzero second mask is placed only at a cycle where both masks each find a free allowed port. In commit mode both of those ports are booked at that cycle.
- R7: The eligible start cycle is the larger of `req_start` and `req_dep` when `req_dependent` is 1. It is `req_start` alone when `req_dependent` is 0.
- R8: A probe request (`req_commit` = 0) leaves the map unchanged. Only commit requests book slots.
- R9: The search examines exactly one cycle per clock. `done` rises (result − start + 1) clocks after acceptance on success, and (max(start, DEPTH) − start + 1) clocks after acceptance on failure. `done` is a one-clock pulse with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the whole reservation map |
| req_valid | input | 1 | Request strobe, accepted when `busy` is low |
| req_mask1 | input | 3 | Port mask of the first micro-op; zero marks an eliminated op |
| req_mask2 | input | 3 | Port mask of the second micro-op; zero for a single micro-op |
| req_start | input | CW | Start cycle of the search |
| req_dep | input | CW | Dependency cycle |
| req_dependent | input | 1 | Use the later of start and dependency cycle |
| req_commit | input | 1 | 1 books the found ports, 0 only probes |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-clock result pulse |
| fail | output | 1 | With `done`: no fit inside the window |
| res_cycle | output | CW | With `done`: the chosen cycle |

## Verification
The bench builds the block with an 8-cycle window, which gives a 4-bit cycle field. At that size every pair of micro-op masks can be swept against every start cycle up to two past the window end, while the map keeps filling and is periodically cleared. This brings port collisions, full cycles, window overflow and start cycles beyond the window all within reach. A bench-side map model predicts each result and each latency. Directed sequences pin down the port priority order, probe versus commit behaviour and dependency handling with values worked out by hand.

// File: rtl/port_sched_pkg.sv
package port_sched_pkg;
  localparam int NPORT = 3;
  // mask/map bit positions
  localparam int PB_A = 0;
  localparam int PB_B = 1;
  localparam int PB_C = 2;

  typedef logic [NPORT-1:0] pmask_t;

  typedef enum logic {
    S_IDLE   = 1'b0,
    S_SEARCH = 1'b1
  } sched_st_e;
endpackage

// File: rtl/port_pick.sv
module port_pick
  import port_sched_pkg::*;
(
  input  pmask_t mask,
  input  pmask_t occ_row,
  output pmask_t grant,
  output logic   hit
);
  // fixed priority: port C, then port A, then port B
  always_comb begin
    grant = '0;
    if (mask[PB_C] && !occ_row[PB_C]) begin
      grant[PB_C] = 1'b1;
    end else if (mask[PB_A] && !occ_row[PB_A]) begin
      grant[PB_A] = 1'b1;
    end else if (mask[PB_B] && !occ_row[PB_B]) begin
      grant[PB_B] = 1'b1;
    end
  end

  assign hit = |grant;
endmodule

// File: rtl/resv_map.sv
module resv_map
  import port_sched_pkg::*;
#(
  parameter int DEPTH = 174,
  parameter int CW    = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [CW-1:0]          wr_idx,
  input  pmask_t                 wr_bits,
  output logic [DEPTH*NPORT-1:0] occ
);
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    pmask_t row_q;
    logic   row_en;

    assign row_en = clr || (wr_en && (wr_idx == CW'(r)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (row_en) begin
        row_q <= clr ? '0 : (row_q | wr_bits);
      end
    end

    assign occ[r*NPORT +: NPORT] = row_q;
  end
endmodule

// File: rtl/port_resv_sched.sv
module port_resv_sched
  import port_sched_pkg::*;
#(
  parameter  int DEPTH = 174,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          req_valid,
  input  logic [2:0]    req_mask1,
  input  logic [2:0]    req_mask2,
  input  logic [CW-1:0] req_start,
  input  logic [CW-1:0] req_dep,
  input  logic          req_dependent,
  input  logic          req_commit,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [CW-1:0] res_cycle
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  sched_st_e st_q, st_d;
  logic [CW-1:0] cur_q, cur_d;
  pmask_t m1_q, m2_q;
  logic   cmt_q;
  logic   ld;
  logic   done_q, done_d, fail_q, fail_d;
  logic [CW-1:0] res_q, res_d;

  logic [DEPTH*NPORT-1:0] occ;
  logic [CW-1:0] base;
  logic   in_win;
  pmask_t row;
  pmask_t msk [2];
  pmask_t gnt [2];
  logic [1:0] hit;
  logic   fit;
  logic   wr_en;

  // eligible start cycle
  assign base = (req_dependent && (req_dep > req_start)) ? req_dep : req_start;

  assign in_win = (cur_q < LIMIT);

  always_comb begin
    row = '1;
    if (in_win) row = occ[NPORT*int'(cur_q) +: NPORT];
  end

  assign msk[0] = m1_q;
  assign msk[1] = m2_q;

  for (genvar g = 0; g < 2; g++) begin : g_pick
    port_pick u_pick (
      .mask    (msk[g]),
      .occ_row (row),
      .grant   (gnt[g]),
      .hit     (hit[g])
    );
  end

  assign fit   = hit[0] && ((m2_q == '0) || hit[1]);
  assign wr_en = (st_q == S_SEARCH) && in_win && fit && cmt_q;

  resv_map #(.DEPTH(DEPTH), .CW(CW)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr_en   (wr_en),
    .wr_idx  (cur_q),
    .wr_bits (gnt[0] | gnt[1]),
    .occ     (occ)
  );

  // next state
  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    ld     = 1'b0;
    done_d = 1'b0;
    fail_d = 1'b0;
    res_d  = res_q;
    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          if (req_mask1 == '0) begin
            done_d = 1'b1;
            res_d  = base;
          end else begin
            st_d  = S_SEARCH;
            cur_d = base;
            ld    = 1'b1;
          end
        end
      end
      S_SEARCH: begin
        if (!in_win) begin
          done_d = 1'b1;
          fail_d = 1'b1;
          res_d  = cur_q;
          st_d   = S_IDLE;
        end else if (fit) begin
          done_d = 1'b1;
          res_d  = cur_q;
          st_d   = S_IDLE;
        end else begin
          cur_d = cur_q + CW'(1);
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      done_q <= done_d;
      fail_q <= fail_d;
      res_q  <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q  <= '0;
      m2_q  <= '0;
      cmt_q <= 1'b0;
    end else if (ld) begin
      m1_q  <= req_mask1;
      m2_q  <= req_mask2;
      cmt_q <= req_commit;
    end
  end

  assign busy      = (st_q == S_SEARCH);
  assign done      = done_q;
  assign fail      = fail_q;
  assign res_cycle = res_q;
endmodule

// File: rtl/port_resv_sched_chk.sv
module port_resv_sched_chk #(
  parameter  int DEPTH = 174,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr,
  input logic                 req_valid,
  input logic [2:0]           req_mask1,
  input logic                 busy,
  input logic                 done,
  input logic                 fail,
  input logic [CW-1:0]        res_cycle,
  input logic                 cmt_q,
  input logic [DEPTH*3-1:0]   occ
);
  // R1: clear empties the map
  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (occ == '0));

  // R8: a probe search never changes the map
  assert_probe_keeps_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmt_q && !clr) |=> $stable(occ));

  // R5: eliminated op completes at once without failure
  assert_elim_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (req_mask1 == '0)) |=> (done && !fail));

  // R5: eliminated op books nothing
  assert_elim_no_book_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (req_mask1 == '0) && !clr) |=> $stable(occ));

  // R4: a searched success lies inside the window
  assert_found_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail && $past(busy)) |-> (int'(res_cycle) < DEPTH));

  // R9: the result pulse comes with the block idle
  assert_done_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind port_resv_sched port_resv_sched_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .req_valid (req_valid),
  .req_mask1 (req_mask1),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .res_cycle (res_cycle),
  .cmt_q     (cmt_q),
  .occ       (occ)
);

// File: tb/port_resv_sched_bench.sv
`timescale 1ns/100ps
module port_resv_sched_bench;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic          clk;
  logic          rst_n;
  logic          clr;
  logic          req_valid;
  logic [2:0]    req_mask1;
  logic [2:0]    req_mask2;
  logic [CW-1:0] req_start;
  logic [CW-1:0] req_dep;
  logic          req_dependent;
  logic          req_commit;
  logic          busy;
  logic          done;
  logic          fail;
  logic [CW-1:0] res_cycle;

  int n_chk = 0;
  int n_bad = 0;
  bit [2:0] mrow [DEPTH];

  port_resv_sched #(.DEPTH(DEPTH)) u_port_resv_sched (
    .clk(clk), .rst_n(rst_n), .clr(clr), .req_valid(req_valid),
    .req_mask1(req_mask1), .req_mask2(req_mask2), .req_start(req_start),
    .req_dep(req_dep), .req_dependent(req_dependent), .req_commit(req_commit),
    .busy(busy), .done(done), .fail(fail), .res_cycle(res_cycle)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit [2:0] mpick(input bit [2:0] m, input bit [2:0] r);
    if (m[2] && !r[2]) return 3'b100;
    if (m[0] && !r[0]) return 3'b001;
    if (m[1] && !r[1]) return 3'b010;
    return 3'b000;
  endfunction

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int i = 0; i < DEPTH; i++) mrow[i] = 3'b000;
  endtask

  // hand: expected cycle, -1 expected failure, -2 no hand value
  task automatic run(input int m1, input int m2, input int s, input int d,
                     input bit dep, input bit cmt, input int hand, input string tag);
    int base, c, el, lat, er;
    bit ef, found;
    bit [2:0] g1, g2;
    base = (dep && d > s) ? d : s;
    ef = 1'b0; er = base; el = 0;
    if (m1 != 0) begin
      c = base; found = 1'b0;
      while (c < DEPTH && !found) begin
        g1 = mpick(3'(m1), mrow[c]);
        g2 = mpick(3'(m2), mrow[c]);
        if (g1 != 3'b000 && (m2 == 0 || g2 != 3'b000)) found = 1'b1;
        else c++;
      end
      if (found) begin
        er = c; el = c - base + 1;
        if (cmt) mrow[c] = mrow[c] | g1 | g2;
      end else begin
        ef = 1'b1;
        if (base < DEPTH) c = DEPTH;
        el = c - base + 1;
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_mask1 = 3'(m1); req_mask2 = 3'(m2);
    req_start = CW'(s); req_dep = CW'(d); req_dependent = dep; req_commit = cmt;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    chk(fail == ef, {tag, " fail flag"}, int'(fail), int'(ef));
    if (!ef) chk(int'(res_cycle) == er, {tag, " cycle"}, int'(res_cycle), er);
    chk(lat == el, {tag, " R9 latency"}, lat, el);
    if (hand == -1) chk(fail == 1'b1, {tag, " hand fail"}, int'(fail), 1);
    else if (hand >= 0) chk(!fail && int'(res_cycle) == hand, {tag, " hand cycle"},
                            int'(res_cycle), hand);
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse width", int'(done), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int k;
    rst_n = 1'b0; clr = 1'b0; req_valid = 1'b0; req_mask1 = '0; req_mask2 = '0;
    req_start = '0; req_dep = '0; req_dependent = 1'b0; req_commit = 1'b0;
    for (int i = 0; i < DEPTH; i++) mrow[i] = 3'b000;
    repeat (3) @(negedge clk);
    chk(!done && !busy, "R1 reset outputs", int'(done) + int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 priority then R3 advance
    run(7, 0, 0, 0, 0, 1, 0, "R2 first full mask");
    run(4, 0, 0, 0, 0, 0, 1, "R2 port C taken first");
    run(1, 0, 0, 0, 0, 0, 0, "R2 port A still free");
    run(7, 0, 0, 0, 0, 1, 0, "R2 second full mask");
    run(1, 0, 0, 0, 0, 0, 1, "R2 port A taken second");
    run(2, 0, 0, 0, 0, 0, 0, "R2 port B still free");
    run(7, 0, 0, 0, 0, 1, 0, "R2 third full mask");
    run(7, 0, 0, 0, 0, 1, 1, "R3 full cycle skipped");

    // R1 clear
    do_clear();
    run(7, 0, 0, 0, 0, 0, 0, "R1 cleared map");
    run(2, 0, 0, 0, 0, 0, 0, "R1 cleared port B");

    // R4 window end
    do_clear();
    run(2, 0, 7, 0, 0, 1, 7, "R4 last cycle");
    run(2, 0, 7, 0, 0, 1, -1, "R4 overflow");
    run(1, 0, 12, 0, 0, 0, -1, "R4 start past window");

    // R5 eliminated
    do_clear();
    run(0, 4, 5, 0, 0, 1, 5, "R5 eliminated");
    run(4, 0, 5, 0, 0, 0, 5, "R5 nothing booked");
    run(0, 0, 14, 0, 0, 1, 14, "R5 eliminated past window");

    // R6 two micro-ops
    do_clear();
    run(2, 0, 0, 0, 0, 1, 0, "R6 book port B");
    run(2, 4, 0, 0, 0, 1, 1, "R6 pair shifted");
    run(4, 0, 1, 0, 0, 0, 2, "R6 port C booked");
    run(2, 0, 1, 0, 0, 0, 2, "R6 port B booked");
    run(1, 4, 0, 0, 0, 0, 0, "R6 pair fits at 0");

    // R7 dependency
    do_clear();
    run(1, 0, 2, 5, 1, 1, 5, "R7 dep later");
    run(1, 0, 2, 5, 0, 0, 2, "R7 dep ignored");
    run(1, 0, 6, 3, 1, 0, 6, "R7 start later");

    // R8 probe
    do_clear();
    run(4, 0, 0, 0, 0, 0, 0, "R8 probe one");
    run(4, 0, 0, 0, 0, 0, 0, "R8 probe two");
    run(4, 0, 0, 0, 0, 1, 0, "R8 commit");
    run(4, 0, 0, 0, 0, 0, 1, "R8 after commit");

    // sweep of all mask pairs over start cycles
    do_clear();
    k = 0;
    for (int m1 = 0; m1 < 8; m1++) begin
      for (int m2 = 0; m2 < 8; m2++) begin
        for (int s = 0; s < DEPTH + 2; s++) begin
          run(m1, m2, s, (k * 5) % 12, (k % 3) == 0, (k % 4) != 3, -2,
              "R3/R6/R7 sweep");
          k++;
          if ((k % 24) == 0) do_clear();
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule